// File: doc/BRIEF.md
# Step-Down Converter Cycle Controller

This block is the digital timing core of a synchronous buck converter. It divides a fast system clock into a fixed switching period. In each period it decides when the high-side and low-side power switches are driven. The analog parts of the loop sit outside the block and reach it as single-bit flags:

- the current-ramp comparator trip,
- the high-side overcurrent flag,
- an inductor-current-below-threshold flag,
- an output-above-setpoint flag.

In normal PWM operation the high side is driven from early in each period. It is released by whichever comes first: a ramp trip, an overcurrent, or the duty ceiling. The low side is then driven for the rest of the period.

A mode input selects light-load skip operation. In skip mode a period with the output above setpoint is left idle, with both switches off. Any other period drives the high side for a fixed pulse that ignores the ramp comparator. Whenever the inductor current drops under the threshold, the low side is released so the current never reverses. A dead time of `DEAD` clocks with both gates low separates every hand-over between the switches. A run input clears everything when it is low.

The controller is a six-state machine:

- **PH_IDLE**: disabled.
- **PH_HS_DEAD**: gap before the high side.
- **PH_HS_ON**: high side driven.
- **PH_LS_DEAD**: gap before the low side.
- **PH_LS_ON**: low side driven.
- **PH_FLOAT**: both off until the period ends.

The transitions are:

- **run drop**: any state goes to PH_IDLE.
- **period wrap**: any state goes to PH_HS_DEAD, or to PH_FLOAT for a skipped period.
- **gap expiry**: PH_HS_DEAD goes to PH_HS_ON, and PH_LS_DEAD goes to PH_LS_ON.
- **pulse end**: PH_HS_ON goes to PH_LS_DEAD.
- **zero-current release**: PH_LS_DEAD or PH_LS_ON goes to PH_FLOAT, in skip mode only.

Position p of a period is the number of clocks since the edge on which the period began.

Top module: `buck_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low or `run_en` is low, both gates are low from the next clock. The first clock edge with `run_en` high begins a new period at position 0.
- R2: A period lasts `PERIOD` clocks. In a PWM period the high-side gate rises at position `DEAD` and at no other position.
- R3: In PWM mode, `ramp_trip` high at position t while the high side is driven makes the high-side gate low from position t+1.
- R4: `hs_ilim` high at position t while the high side is driven makes the high-side gate low from position t+1, in both modes.
- R5: The high-side gate is never high at a position of `MAX_ON` or later.
- R6: After the high side drops, both gates stay low for `DEAD` clocks. The low side is then driven to the end of the period, unless R10 applies.
- R7: The two gates are never high together. Each hand-over in either direction has at least `DEAD` clocks with both low, including across a period boundary.
- R8: In skip mode, if `out_high` is 1 on the edge that begins a period, both gates stay low for that whole period.
- R9: In skip mode, a period not skipped drives the high side from position `DEAD` through position `SKIP_ON`-1. `ramp_trip` has no effect on this.
- R10: In skip mode, `il_low` high at position t while the low side is driven or pending makes the low-side gate low from position t+1 to the end of the period.
- R11: In PWM mode, `il_low` and `out_high` have no effect on either gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Converter run; low forces both gates off and restarts the period |
| skip_sel | input | 1 | 1 selects skip mode, 0 selects PWM mode |
| ramp_trip | input | 1 | Current ramp has crossed the error voltage |
| hs_ilim | input | 1 | High-side current above limit |
| il_low | input | 1 | Inductor current below the skip threshold |
| out_high | input | 1 | Output voltage above setpoint |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |

## Verification
A period counter out of step with the state machine shows within one period. The high-side rising edge moves off position `DEAD`, and the low side's last clock moves off the final position. Both are visible the first time the bench compares a whole period against its position-by-position expectation.

A wrong state shows within one clock of the event that should have moved it:

- a missed terminator leaves the high gate up,
- a missed zero-current release leaves the low gate up,
- a wrong wrap decision lights a gate in a period that should be idle.

Consecutive periods are compared end to end, so a hand-over gap that is too short shows at the boundary it crosses.

// File: rtl/buck_pkg.sv
`timescale 1ns/1ps
package buck_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_HS_DEAD = 3'd1,
        PH_HS_ON   = 3'd2,
        PH_LS_DEAD = 3'd3,
        PH_LS_ON   = 3'd4,
        PH_FLOAT   = 3'd5
    } phase_t;
endpackage

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
module cycle_timer #(
    parameter int PERIOD = 100,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    // Held at the last position while disabled, so the first enabled edge wraps.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= LAST;
        else if (!run_en)
            cnt <= LAST;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign wrap = run_en && (cnt == LAST);

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R2
endmodule

// File: rtl/phase_fsm.sv
`timescale 1ns/1ps
module phase_fsm
    import buck_pkg::*;
#(
    parameter int PERIOD  = 100,
    parameter int MAX_ON  = 94,
    parameter int SKIP_ON = 30,
    parameter int DEAD    = 2,
    localparam int CW = $clog2(PERIOD),
    localparam int DW = (DEAD > 1) ? $clog2(DEAD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          skip_sel,
    input  logic          ramp_trip,
    input  logic          hs_ilim,
    input  logic          il_low,
    input  logic          out_high,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    output logic          hs_gate,
    output logic          ls_gate
);
    localparam logic [DW-1:0] GAP_LOAD = DW'(DEAD - 1);
    localparam logic [CW-1:0] CAP_POS  = CW'(MAX_ON - 1);
    localparam logic [CW-1:0] SKIP_POS = CW'(SKIP_ON - 1);

    phase_t        state, nxt;
    logic [DW-1:0] gap, gap_nxt;
    logic          pulse_end;

    always_comb begin
        pulse_end = hs_ilim || (cnt == CAP_POS) ||
                    (skip_sel ? (cnt == SKIP_POS) : ramp_trip);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            gap   <= '0;
        end else begin
            state <= nxt;
            gap   <= gap_nxt;
        end
    end

    // Next state: run drop, then period wrap, then per-state transitions
    always_comb begin
        nxt     = state;
        gap_nxt = (gap != '0) ? gap - 1'b1 : '0;
        if (!run_en) begin
            nxt = PH_IDLE;
        end else if (wrap) begin
            if (skip_sel && out_high) begin
                nxt = PH_FLOAT;
            end else begin
                nxt     = PH_HS_DEAD;
                gap_nxt = GAP_LOAD;
            end
        end else begin
            unique case (state)
                PH_IDLE:    nxt = PH_IDLE;
                PH_HS_DEAD: if (gap == '0) nxt = PH_HS_ON;
                PH_HS_ON: begin
                    if (pulse_end) begin
                        nxt     = PH_LS_DEAD;
                        gap_nxt = GAP_LOAD;
                    end
                end
                PH_LS_DEAD: begin
                    if (skip_sel && il_low)
                        nxt = PH_FLOAT;
                    else if (gap == '0)
                        nxt = PH_LS_ON;
                end
                PH_LS_ON:   if (skip_sel && il_low) nxt = PH_FLOAT;
                PH_FLOAT:   nxt = PH_FLOAT;
                default:    nxt = PH_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        hs_gate = 1'b0;
        ls_gate = 1'b0;
        unique case (state)
            PH_HS_ON: hs_gate = 1'b1;
            PH_LS_ON: ls_gate = 1'b1;
            PH_IDLE, PH_HS_DEAD, PH_LS_DEAD, PH_FLOAT: ;
            default: ;
        endcase
    end

    AST_LS_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ls_gate |=> !hs_gate); // R7
    AST_HS_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate |=> !ls_gate); // R7
    AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_sel && il_low && ls_gate) |=> !ls_gate); // R10
    AST_RUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_gate && !ls_gate)); // R1
    AST_SKIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && skip_sel && out_high) |=> (!hs_gate && !ls_gate)); // R8
endmodule

// File: rtl/buck_cycle_ctrl.sv
`timescale 1ns/1ps
module buck_cycle_ctrl #(
    parameter int PERIOD  = 100,
    parameter int MAX_ON  = 94,
    parameter int SKIP_ON = 30,
    parameter int DEAD    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic skip_sel,
    input  logic ramp_trip,
    input  logic hs_ilim,
    input  logic il_low,
    input  logic out_high,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;
    logic          wrap;

    cycle_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    phase_fsm #(
        .PERIOD  (PERIOD),
        .MAX_ON  (MAX_ON),
        .SKIP_ON (SKIP_ON),
        .DEAD    (DEAD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .skip_sel  (skip_sel),
        .ramp_trip (ramp_trip),
        .hs_ilim   (hs_ilim),
        .il_low    (il_low),
        .out_high  (out_high),
        .wrap      (wrap),
        .cnt       (cnt),
        .hs_gate   (hs_gate),
        .ls_gate   (ls_gate)
    );

    AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate |-> (cnt < CW'(MAX_ON))); // R5
    AST_HS_RISE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (cnt == CW'(DEAD))); // R2
endmodule

// File: tb/sim_buck_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_buck_cycle_ctrl;
    localparam int P   = 100;
    localparam int MX  = 94;
    localparam int SK  = 30;
    localparam int DT  = 2;
    localparam int NONE = 100000;

    logic clk = 1'b0;
    logic rst_n, run_en, skip_sel, ramp_trip, hs_ilim, il_low, out_high;
    logic hs_gate, ls_gate;
    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 0;

    always #2.5 clk = ~clk;

    buck_cycle_ctrl #(.PERIOD(P), .MAX_ON(MX), .SKIP_ON(SK), .DEAD(DT)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .skip_sel(skip_sel),
        .ramp_trip(ramp_trip), .hs_ilim(hs_ilim), .il_low(il_low),
        .out_high(out_high), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    task automatic check(input string tag, input int p, input logic eh, input logic el);
        vectors++;
        if (hs_gate !== eh || ls_gate !== el) begin
            errors++;
            $display("FAIL %s pos=%0d hs=%0b exp %0b ls=%0b exp %0b",
                     tag, p, hs_gate, eh, ls_gate, el);
        end
    endtask

    // One full period; entered just after the negedge at the previous period's last position.
    task automatic run_cycle(input string tag, input bit skip, input bit above,
                             input int trip_t, input int ilim_t, input int zero_t);
        int hs_end, ls_beg, ls_end;
        bit idle;
        logic eh, el;
        skip_sel  = skip;
        out_high  = above;
        ramp_trip = 0;
        hs_ilim   = 0;
        il_low    = 0;
        idle   = skip && above;
        hs_end = (skip ? SK : MX) - 1;
        if (!skip && trip_t < hs_end) hs_end = trip_t;
        if (ilim_t < hs_end) hs_end = ilim_t;
        ls_beg = hs_end + DT + 1;
        ls_end = (skip && zero_t < P - 1) ? zero_t : P - 1;
        for (int p = 0; p < P; p++) begin
            @(negedge clk);
            eh = !idle && (p >= DT) && (p <= hs_end);
            el = !idle && (p >= ls_beg) && (p <= ls_end);
            check(tag, p, eh, el);
            ramp_trip = (p >= trip_t);
            hs_ilim   = (p >= ilim_t);
            il_low    = (p >= zero_t);
        end
    endtask

    task automatic reset_test();
        rst_n = 0; run_en = 0; skip_sel = 0; ramp_trip = 0;
        hs_ilim = 0; il_low = 0; out_high = 0;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset", 0, 1'b0, 1'b0);
        end
        rst_n = 1;
        repeat (3) begin
            @(negedge clk);
            check("R1 not running", 0, 1'b0, 1'b0);
        end
        run_en = 1;
    endtask

    task automatic disable_midcycle();
        skip_sel = 0; out_high = 0; ramp_trip = 0; hs_ilim = 0; il_low = 0;
        for (int p = 0; p <= 40; p++) begin
            @(negedge clk);
            check("R1 pre-drop", p, (p >= DT && p <= 20), (p >= 23));
            ramp_trip = (p >= 20);
        end
        run_en = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R1 dropped", 41 + k, 1'b0, 1'b0);
        end
        run_en = 1;
    endtask

    initial begin
        reset_test();
        run_cycle("R1 R2 R3 R6 first period", 0, 0, 40, NONE, NONE);
        run_cycle("R3 R7 back-to-back", 0, 0, 25, NONE, NONE);
        run_cycle("R4 pwm ilim", 0, 0, NONE, 30, NONE);
        run_cycle("R5 duty cap", 0, 0, NONE, NONE, NONE);
        run_cycle("R7 after cap", 0, 0, 60, NONE, NONE);
        run_cycle("R11 pwm ignores flags", 0, 1, 40, NONE, 50);
        run_cycle("R8 skip idle", 1, 1, NONE, NONE, NONE);
        run_cycle("R8 skip idle again", 1, 1, 5, 5, 5);
        run_cycle("R9 skip fixed pulse", 1, 0, 10, NONE, NONE);
        run_cycle("R10 skip zero release", 1, 0, NONE, NONE, 60);
        run_cycle("R4 skip ilim", 1, 0, NONE, 15, 70);
        run_cycle("R10 skip zero in gap", 1, 0, NONE, NONE, 31);
        disable_midcycle();
        run_cycle("R1 restart aligned", 0, 0, 50, NONE, NONE);
        run_cycle("R2 steady", 0, 0, 70, NONE, NONE);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule